// File: doc/BRIEF.md
# UART Status and Interrupt Register Block

This block sits between a UART receiver/transmitter pair and the CPU register bus. It collects one-cycle error pulses from the receiver (overrun, parity, framing, break) into sticky flags, tracks the receive-FIFO and transmit-FIFO threshold conditions, and presents this state through two status views that share their low error bits. Reading either view clears the shared bits in both views.

The block also combines the enabled sources into a single interrupt request. It includes a transmit hold mechanism. When software reads the interrupt identification register while the transmit-FIFO term is what drives the interrupt, that term is held off. It stays held off until a character is pushed into the transmit FIFO or the transmit interrupt enable is written to 0. This prevents the same transmit interrupt from firing again and again. The FIFOs, the shifters and baud generation are outside this block. Only the FIFO levels, thresholds, push/pop strobes and the transmitter idle flag come in.

Top module: `uart_stat_irq`

## Requirements
- R1: Line-status view (address 0): bit 0 = receive request, bit 1 = overrun, bit 2 = parity error, bit 3 = framing error, bit 4 = break, bit 5 = transmit FIFO status, bit 6 = transmitter idle. Bits 31:7 of every read return 0.
- R2: After reset, read data is 0, the interrupt output is 0 and all interrupt enables are 0. With the transmitter idle and its FIFO empty, a line-status read then returns 0x60.
- R3: A one-cycle pulse on any receiver error input sets its flag. The flag stays set until a clearing read.
- R4: The receive-status view (address 1) has bits 4:0 laid out as in the line-status view and bits 7:5 read as 0. A read of either view clears the four error flags and acknowledges the receive request, and this applies to both views.
- R5: An error pulse that arrives in the same cycle as a clearing read leaves its flag set.
- R6: Line-status bit 6 follows the transmitter idle input. Bit 5 is 1 when the transmit FIFO level is less than or equal to its threshold.
- R7: The receive request is 1 when the receive FIFO level is above its threshold. It is forced to 0 in any cycle with a receive-FIFO pop. Writing 0 to bit 0 of the line-status view acknowledges it. An acknowledge lasts until the level drops to or below the threshold.
- R8: Enable register (address 3): bit 0 = receive, bit 1 = transmit, bit 2 = errors; it is readable. The interrupt output is the OR of the enabled receive request, the enabled and unheld transmit status, and the enabled OR of the error flags. Identification register (address 2) reads bit 0 = receive pending, bit 1 = transmit pending, bit 2 = error pending.
- R9: A read of the identification register while the transmit term is pending enters the hold state. While held, the transmit term raises no interrupt.
- R10: The hold state is left when a character is pushed into the transmit FIFO, or when the enable register is written with bit 1 equal to 0.
- R11: Read data appears in the cycle after the read strobe. The side effects of a read (clear, acknowledge, hold entry) happen only in the first cycle of a strobe that stays high for several cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| rx_ovr_p | input | 1 | Receiver overrun pulse |
| rx_par_p | input | 1 | Receiver parity error pulse |
| rx_frm_p | input | 1 | Receiver framing error pulse |
| rx_brk_p | input | 1 | Receiver break pulse |
| rx_lvl | input | 6 | Receive FIFO fill level |
| rx_thr | input | 6 | Receive FIFO threshold |
| rx_pop | input | 1 | Receive FIFO read strobe |
| tx_lvl | input | 6 | Transmit FIFO fill level |
| tx_thr | input | 6 | Transmit FIFO threshold |
| tx_push | input | 1 | Transmit FIFO write strobe |
| tx_idle | input | 1 | Transmitter idle (empty or disabled) |
| irq | output | 1 | Interrupt request |

## Verification
Each error input is pulsed on its own, so that a swapped bit position shows up in the read value. Separate reads through the two views tell the shared clear apart from a clear that affects only one view. An error pulse placed exactly on a clearing read, and a read strobe held for three cycles with a pulse in the middle, separate "set wins" and "clear once per strobe" from their wrong variants. Levels exactly at, one below and one above each threshold locate the comparison edges. The transmit hold is entered and then left by each of its two exits, with the interrupt output watched in between.

// File: rtl/ustat_pkg.sv
// Package: register addresses and bit positions shared by the status block.
// Assumes a 2-bit word address on the register bus.
package ustat_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        A_LINE  = 2'd0,
        A_RXST  = 2'd1,
        A_INTID = 2'd2,
        A_INTEN = 2'd3
    } reg_addr_e;

    localparam int NUM_ERR   = 4;   // overrun, parity, framing, break
    localparam int B_RXREQ   = 0;
    localparam int B_ERR_LO  = 1;   // errors occupy bits 4:1
    localparam int B_TXFST   = 5;
    localparam int B_TXIDLE  = 6;

    localparam int E_RX  = 0;
    localparam int E_TX  = 1;
    localparam int E_ERR = 2;
    localparam int NUM_EN = 3;
endpackage

// File: rtl/ustat_sticky.sv
// Sticky flag bank: each bit sets on a one-cycle pulse and clears on a
// clear strobe. A pulse in the same cycle as the clear wins.
// Assumes pulses and clear are synchronous to clk.
module ustat_sticky #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_p,
    input  logic         clr,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // Hold one flag: set has priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags[i] <= 1'b0;
            else if (set_p[i])
                flags[i] <= 1'b1;
            else if (clr)
                flags[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/ustat_rx_req.sv
// Receive request: level above threshold, masked during a FIFO pop and
// after an acknowledge until the level has fallen to the threshold.
// Assumes level and threshold share one width.
module ustat_rx_req #(
    parameter int LVL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] lvl,
    input  logic [LVL_W-1:0] thr,
    input  logic             pop,
    input  logic             ack,
    output logic             req
);
    logic above;
    logic ack_q;

    // Compare the fill level against the threshold.
    always_comb above = (lvl > thr);

    // Remember an acknowledge while the level stays above the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ack_q <= 1'b0;
        else if (!above)
            ack_q <= 1'b0;
        else if (ack)
            ack_q <= 1'b1;
    end

    // Form the visible request.
    always_comb req = above && !ack_q && !pop;
endmodule

// File: rtl/ustat_tx_hold.sv
// Transmit interrupt hold: entered by an identification read while the
// transmit term is pending, left by a FIFO push or enable write of 0.
// Exit has priority over entry.
module ustat_tx_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic enter,
    input  logic push,
    input  logic en_off,
    output logic hold
);
    // Track the hold state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold <= 1'b0;
        else if (push || en_off)
            hold <= 1'b0;
        else if (enter)
            hold <= 1'b1;
    end
endmodule

// File: rtl/uart_stat_irq.sv
// UART status and interrupt register block. Decodes the register bus,
// keeps the enable register, builds both status views, the identification
// word and the interrupt output. Read data is registered; read side
// effects fire on the first cycle of a read strobe only.
module uart_stat_irq
    import ustat_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LVL_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              rx_ovr_p,
    input  logic              rx_par_p,
    input  logic              rx_frm_p,
    input  logic              rx_brk_p,
    input  logic [LVL_W-1:0]  rx_lvl,
    input  logic [LVL_W-1:0]  rx_thr,
    input  logic              rx_pop,
    input  logic [LVL_W-1:0]  tx_lvl,
    input  logic [LVL_W-1:0]  tx_thr,
    input  logic              tx_push,
    input  logic              tx_idle,
    output logic              irq
);
    localparam int VIEW_W = B_TXIDLE + 1;

    logic               rd_q;
    logic               rd_first;
    logic               stat_rd;
    logic               id_rd;
    logic               line_wr;
    logic               en_wr;
    logic [NUM_ERR-1:0] err_pulse;
    logic [NUM_ERR-1:0] err_q;
    logic [NUM_EN-1:0]  int_en;
    logic               rx_flag;
    logic               rx_ack;
    logic               tx_req;
    logic               hold_q;
    logic               pend_rx;
    logic               pend_tx;
    logic               pend_err;
    logic               hold_enter;
    logic               en_off;
    logic [VIEW_W-1:0]  line_view;
    logic [VIEW_W-1:0]  rx_view;
    logic [DATA_W-1:0]  rd_mux;

    // Remember the previous strobe to find the first cycle of a read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_q <= 1'b0;
        else
            rd_q <= rd_en;
    end

    // Decode bus accesses.
    always_comb begin
        rd_first = rd_en && !rd_q;
        stat_rd  = rd_first && (addr == A_LINE || addr == A_RXST);
        id_rd    = rd_first && (addr == A_INTID);
        line_wr  = wr_en && (addr == A_LINE);
        en_wr    = wr_en && (addr == A_INTEN);
    end

    // Order the error pulses by their status-bit position.
    always_comb err_pulse = {rx_brk_p, rx_frm_p, rx_par_p, rx_ovr_p};

    ustat_sticky #(.N(NUM_ERR)) u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .set_p (err_pulse),
        .clr   (stat_rd),
        .flags (err_q)
    );

    // A status read or a write of 0 to bit 0 acknowledges the receive request.
    always_comb rx_ack = stat_rd || (line_wr && !wdata[B_RXREQ]);

    ustat_rx_req #(.LVL_W(LVL_W)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (rx_lvl),
        .thr   (rx_thr),
        .pop   (rx_pop),
        .ack   (rx_ack),
        .req   (rx_flag)
    );

    // Keep the interrupt enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            int_en <= '0;
        else if (en_wr)
            int_en <= wdata[NUM_EN-1:0];
    end

    // Transmit FIFO status and the pending terms.
    always_comb begin
        tx_req     = (tx_lvl <= tx_thr);
        pend_rx    = int_en[E_RX] && rx_flag;
        pend_tx    = int_en[E_TX] && tx_req && !hold_q;
        pend_err   = int_en[E_ERR] && (|err_q);
        hold_enter = id_rd && pend_tx;
        en_off     = en_wr && !wdata[E_TX];
    end

    ustat_tx_hold u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .enter  (hold_enter),
        .push   (tx_push),
        .en_off (en_off),
        .hold   (hold_q)
    );

    // Combine the enabled sources.
    always_comb irq = pend_rx || pend_tx || pend_err;

    // Build the two status views.
    always_comb begin
        rx_view                               = '0;
        rx_view[B_RXREQ]                      = rx_flag;
        rx_view[B_ERR_LO +: NUM_ERR]          = err_q;
        line_view                             = rx_view;
        line_view[B_TXFST]                    = tx_req;
        line_view[B_TXIDLE]                   = tx_idle;
    end

    // Select the read word.
    always_comb begin
        rd_mux = '0;
        case (addr)
            A_LINE:  rd_mux[VIEW_W-1:0] = line_view;
            A_RXST:  rd_mux[VIEW_W-1:0] = rx_view;
            A_INTID: rd_mux[NUM_EN-1:0] = {pend_err, pend_tx, pend_rx};
            default: rd_mux[NUM_EN-1:0] = int_en;
        endcase
    end

    // Register the read data.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en)
            rdata <= rd_mux;
    end
endmodule

// File: rtl/ustat_checker.sv
// Checker for uart_stat_irq, attached by bind. Observes ports and the
// internal state that the separate submodules drive.
module ustat_checker
    import ustat_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_first,
    input logic [1:0]        addr,
    input logic              wr_en,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic [3:0]        err_pulse,
    input logic [3:0]        err_q,
    input logic              hold_q,
    input logic [2:0]        int_en,
    input logic              irq,
    input logic              tx_push,
    input logic              rx_pop,
    input logic              rx_flag
);
    // R1: upper read bits are always zero
    a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[DATA_W-1:7] == '0);

    // R3: a pulse always leaves its flag set
    a_r3_pulse_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (err_pulse != '0) |=> ((err_q & $past(err_pulse)) == $past(err_pulse)));

    // R4: a clearing read without new pulses empties the flags
    a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_first && (addr == A_LINE || addr == A_RXST) && err_pulse == '0)
        |=> (err_q == '0));

    // R7: pop forces the receive request low
    a_r7_pop_masks: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> !rx_flag);

    // R9: held transmit term alone raises no interrupt
    a_r9_hold_masks: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && !int_en[E_RX] && !int_en[E_ERR]) |-> !irq);

    // R10: a push leaves the hold state
    a_r10_push_exit: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push |=> !hold_q);

    // R10: disabling the transmit source leaves the hold state
    a_r10_enoff_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_INTEN && !wdata[E_TX]) |=> !hold_q);
endmodule

bind uart_stat_irq ustat_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_first  (rd_first),
    .addr      (addr),
    .wr_en     (wr_en),
    .wdata     (wdata),
    .rdata     (rdata),
    .err_pulse (err_pulse),
    .err_q     (err_q),
    .hold_q    (hold_q),
    .int_en    (int_en),
    .irq       (irq),
    .tx_push   (tx_push),
    .rx_pop    (rx_pop),
    .rx_flag   (rx_flag)
);

// File: tb/test_uart_stat_irq.sv
// Directed bench for uart_stat_irq: one task per scenario.
module test_uart_stat_irq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rx_ovr_p = 1'b0, rx_par_p = 1'b0, rx_frm_p = 1'b0, rx_brk_p = 1'b0;
    logic [5:0]  rx_lvl = 6'd0, rx_thr = 6'd4, tx_lvl = 6'd0, tx_thr = 6'd0;
    logic        rx_pop = 1'b0, tx_push = 1'b0, tx_idle = 1'b1;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    uart_stat_irq i_uart_stat_irq (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rx_ovr_p(rx_ovr_p), .rx_par_p(rx_par_p),
        .rx_frm_p(rx_frm_p), .rx_brk_p(rx_brk_p), .rx_lvl(rx_lvl), .rx_thr(rx_thr),
        .rx_pop(rx_pop), .tx_lvl(tx_lvl), .tx_thr(tx_thr), .tx_push(tx_push),
        .tx_idle(tx_idle), .irq(irq)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(posedge clk); #1;
        check(rdata, exp, tag);
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic pulse_err(input int idx);
        @(negedge clk);
        case (idx)
            0: rx_ovr_p = 1'b1;
            1: rx_par_p = 1'b1;
            2: rx_frm_p = 1'b1;
            default: rx_brk_p = 1'b1;
        endcase
        @(negedge clk);
        {rx_brk_p, rx_frm_p, rx_par_p, rx_ovr_p} = 4'b0;
    endtask

    task automatic irq_chk(input logic exp, input string tag);
        @(negedge clk);
        check({31'b0, irq}, {31'b0, exp}, tag);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(rdata, 32'h0, "R2 rdata after reset");
        check({31'b0, irq}, 32'h0, "R2 irq after reset");
        rd_chk(2'd3, 32'h0, "R2 enables after reset");
        rd_chk(2'd0, 32'h60, "R2 R1 line view after reset");
    endtask

    task automatic t_err_bits;
        for (int i = 0; i < 4; i++) begin
            pulse_err(i);
            rd_chk(2'd0, 32'h60 | (32'h1 << (i + 1)), "R1 R3 error bit position");
            rd_chk(2'd0, 32'h60, "R4 flag cleared by read");
        end
    endtask

    task automatic t_alias;
        pulse_err(1);
        pulse_err(3);
        rd_chk(2'd1, 32'h14, "R4 receive view layout");
        rd_chk(2'd0, 32'h60, "R4 receive-view read cleared line view");
        pulse_err(0);
        rd_chk(2'd0, 32'h62, "R4 line view shows overrun");
        rd_chk(2'd1, 32'h00, "R4 line-view read cleared receive view");
    endtask

    task automatic t_collision;
        @(negedge clk); rx_frm_p = 1'b1; rd_en = 1'b1; addr = 2'd0;
        @(posedge clk); #1;
        check(rdata, 32'h60, "R5 read during pulse returns old state");
        @(negedge clk); rx_frm_p = 1'b0; rd_en = 1'b0;
        rd_chk(2'd0, 32'h68, "R5 pulse survived clearing read");
    endtask

    task automatic t_once;
        @(negedge clk); rd_en = 1'b1; addr = 2'd0;
        @(posedge clk); #1;
        @(negedge clk); rx_par_p = 1'b1;
        @(posedge clk); #1;
        check(rdata, 32'h60, "R11 held strobe second cycle");
        @(negedge clk); rx_par_p = 1'b0;
        @(posedge clk); #1;
        check(rdata, 32'h64, "R11 held strobe third cycle");
        @(negedge clk); rd_en = 1'b0;
        rd_chk(2'd0, 32'h64, "R11 no clear after first strobe cycle");
    endtask

    task automatic t_tx_bits;
        @(negedge clk); tx_thr = 6'd3; tx_lvl = 6'd3;
        rd_chk(2'd0, 32'h60, "R6 level equal to threshold");
        @(negedge clk); tx_lvl = 6'd4;
        rd_chk(2'd0, 32'h40, "R6 level above threshold");
        @(negedge clk); tx_idle = 1'b0;
        rd_chk(2'd0, 32'h00, "R6 transmitter busy");
        @(negedge clk); tx_idle = 1'b1; tx_lvl = 6'd0; tx_thr = 6'd0;
    endtask

    task automatic t_rx_req;
        @(negedge clk); rx_lvl = 6'd4;
        rd_chk(2'd0, 32'h60, "R7 level equal to threshold");
        @(negedge clk); rx_lvl = 6'd5;
        rd_chk(2'd0, 32'h61, "R7 level above threshold");
        rd_chk(2'd0, 32'h60, "R7 R4 read acknowledged request");
        @(negedge clk); rx_lvl = 6'd4;
        @(negedge clk); rx_lvl = 6'd5;
        wr(2'd3, 32'h1);
        irq_chk(1'b1, "R8 receive interrupt");
        @(negedge clk); rx_pop = 1'b1;
        #1 check({31'b0, irq}, 32'h0, "R7 pop forces request low");
        @(negedge clk); rx_pop = 1'b0;
        irq_chk(1'b1, "R7 request back after pop");
        wr(2'd0, 32'h0);
        irq_chk(1'b0, "R7 write 0 acknowledges");
        @(negedge clk); rx_lvl = 6'd3;
        @(negedge clk); rx_lvl = 6'd5;
        irq_chk(1'b1, "R7 acknowledge released by level drop");
        wr(2'd3, 32'h0);
        @(negedge clk); rx_lvl = 6'd0;
    endtask

    task automatic t_err_irq;
        wr(2'd3, 32'h4);
        irq_chk(1'b0, "R8 no error yet");
        pulse_err(0);
        irq_chk(1'b1, "R8 error interrupt");
        rd_chk(2'd2, 32'h4, "R8 identification shows error");
        rd_chk(2'd0, 32'h62, "R8 line view before clear");
        irq_chk(1'b0, "R8 error interrupt cleared");
        wr(2'd3, 32'h0);
    endtask

    task automatic t_hold;
        wr(2'd3, 32'h2);
        rd_chk(2'd3, 32'h2, "R8 enable readback");
        irq_chk(1'b1, "R9 transmit interrupt");
        rd_chk(2'd2, 32'h2, "R9 identification shows transmit");
        irq_chk(1'b0, "R9 hold masks transmit");
        rd_chk(2'd2, 32'h0, "R9 held term not pending");
        @(negedge clk); tx_push = 1'b1;
        @(negedge clk); tx_push = 1'b0;
        irq_chk(1'b1, "R10 push leaves hold");
        rd_chk(2'd2, 32'h2, "R9 re-enter hold");
        irq_chk(1'b0, "R9 held again");
        wr(2'd3, 32'h0);
        wr(2'd3, 32'h2);
        irq_chk(1'b1, "R10 enable write 0 leaves hold");
        wr(2'd3, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_err_bits();
        t_alias();
        t_collision();
        rd_chk(2'd0, 32'h60, "R4 collision flag cleared");
        t_once();
        rd_chk(2'd0, 32'h60, "R4 strobe flag cleared");
        t_tx_bits();
        t_rx_req();
        t_err_irq();
        t_hold();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule